// File: doc/BRIEF.md
# E3 G.832 Frame Aligner

This block takes a serial E3 line bit stream, qualified by a per-cycle bit-valid strobe, and locates the boundary of the 537-octet G.832 frame. A frame has 9 rows, 7 overhead octets and 530 payload octets. The block hunts bit by bit for the 16-bit alignment word 0xF628, which is the first two overhead octets. It confirms a candidate by checking the same bit slot exactly one frame later. Once locked, it watches the alignment word in every frame. It declares loss of alignment after four bad frames in a row.

After lock the block produces a byte strobe, the position of each completed byte within the frame, and a frame-start pulse. In the out-of-frame condition it keeps timing bytes from the last good alignment while it hunts for and verifies a new one. A verified new alignment replaces the old timing. Every move into or out of the out-of-frame condition sets a sticky status bit. The status bit clears when read and can raise an interrupt line through an enable bit.

Top module: `e3_frame_align`

## Requirements
- R1: After reset the block is hunting, with in_frame, oof, byte_stb, frame_start and irq low, and both registers reading 0.
- R2: The hunt matches 0xF628, first bit received being the MSB, ending at any bit position of the stream, counting only cycles with bit_valid high.
- R3: A hunt match starts verification. The hunt stops until the 16 bits ending exactly 537×8 valid bits later are compared with 0xF628. If they match, in_frame is high from the cycle after that bit.
- R4: A failed verification returns the block to hunting, and a later genuine word is then acquired normally.
- R5: While in_frame or oof is high, byte_stb pulses for one cycle after the last bit of each byte, and byte_pos gives that byte's position. Position 0 is the first alignment octet and 1 the second, counting up to 536 and wrapping to 0. frame_start pulses together with byte_stb when byte_pos is 0. No byte_stb occurs while hunting or verifying.
- R6: While locked, the two bytes at positions 0 and 1 are compared with 0xF628 in every frame. The fourth consecutive mismatch sets oof and clears in_frame. A matching frame resets the mismatch count.
- R7: With oof high, byte timing continues from the old alignment while the hunt and one-frame verification run as in R3. A successful verification loads the new alignment, clears oof and sets in_frame.
- R8: Each entry into and each exit from oof sets status bit 3 (register address 0). A read of address 0 clears it, unless a new change occurs in the same cycle. Address 0 also shows in_frame at bit 0 and oof at bit 1.
- R9: irq is high exactly while status bit 3 and the enable bit are both 1. The enable is written through reg_wbit at address 1 and reads back at bit 3 of address 1.
- R10: Cycles with bit_valid low change no state, so a stream with idle gaps locks and is timed exactly like a gap-free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | bit_in carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| byte_stb | output | 1 | A frame byte has just completed |
| frame_start | output | 1 | The completed byte is position 0 |
| byte_pos | output | 10 | Position of the completed byte in the frame |
| in_frame | output | 1 | Alignment locked |
| oof | output | 1 | Out-of-frame condition |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 0) |
| reg_addr | input | 1 | 0: status, 1: interrupt enable |
| reg_wbit | input | 1 | Value written to the enable bit |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Out-of-frame change interrupt |

## Verification
The hardest state to reach is the re-acquisition inside the out-of-frame condition. The block must first be locked. It then needs two runs of bad frames, three and four long with a good frame between them, so that the counter reset is also covered. The stimulus then slips the stream by three bits. Old-alignment byte timing is checked across the rest of the first out-of-frame frame. After the slip, the bench checks that the new alignment takes over only at its verification bit. A second hard case is a decoy word placed in the payload ahead of the real one. The decoy's failed verification must also skip the genuine word that arrives while it is pending. Lock must therefore come one frame later than a block that keeps hunting during verification would give.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2,
        ST_LOST   = 2'd3
    } fa_state_e;

    localparam int unsigned REG_DATA_W = 8;
    localparam int unsigned CHG_BIT    = 3;
    localparam int unsigned EN_BIT     = 3;
endpackage

// File: rtl/e3fa_window.sv
module e3fa_window #(
    parameter int unsigned          WORD_W    = 16,
    parameter logic [WORD_W-1:0]    WORD_VAL  = 16'hF628
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic word_match
);
    typedef struct packed {
        logic [WORD_W-2:0] hist;
    } win_t;

    win_t win_d, win_q;
    logic [WORD_W-1:0] window;

    always_comb begin
        win_d  = win_q;
        window = {win_q.hist, bit_in};
        word_match = bit_valid && (window == WORD_VAL);
        if (bit_valid) begin
            win_d.hist = window[WORD_W-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/e3fa_cand.sv
module e3fa_cand #(
    parameter int unsigned FRAME_BITS = 4296,
    parameter int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic start,
    input  logic word_match,
    output logic busy,
    output logic done,
    output logic pass
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } cand_t;

    cand_t cand_d, cand_q;

    always_comb begin
        cand_d = cand_q;
        done   = cand_q.busy && bit_valid && (cand_q.cnt == LAST_CNT);
        pass   = done && word_match;
        if (start) begin
            cand_d.busy = 1'b1;
            cand_d.cnt  = '0;
        end else if (done) begin
            cand_d.busy = 1'b0;
        end else if (cand_q.busy && bit_valid) begin
            cand_d.cnt = cand_q.cnt + 1'b1;
        end
    end

    assign busy = cand_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '0;
        end else begin
            cand_q <= cand_d;
        end
    end
endmodule

// File: rtl/e3fa_timer.sv
module e3fa_timer #(
    parameter int unsigned FRAME_BYTES = 537,
    parameter int unsigned POS_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             load,
    input  logic             run,
    output logic             check_pt,
    output logic             byte_stb,
    output logic             frame_start,
    output logic [POS_W-1:0] byte_pos
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BYTES - 1);
    localparam logic [POS_W-1:0] WORD2_POS = POS_W'(1);
    localparam logic [POS_W-1:0] AFTER_POS = POS_W'(2);

    typedef struct packed {
        logic [2:0]       bit_idx;
        logic [POS_W-1:0] byte_idx;
        logic             stb;
        logic             fs;
        logic [POS_W-1:0] pos;
    } tim_t;

    tim_t tim_d, tim_q;
    logic byte_end;

    always_comb begin
        tim_d     = tim_q;
        tim_d.stb = 1'b0;
        tim_d.fs  = 1'b0;
        byte_end  = bit_valid && (tim_q.bit_idx == 3'd7);
        check_pt  = run && byte_end && (tim_q.byte_idx == WORD2_POS);
        if (load) begin
            tim_d.bit_idx  = '0;
            tim_d.byte_idx = AFTER_POS;
        end else if (bit_valid) begin
            if (byte_end) begin
                tim_d.bit_idx  = '0;
                tim_d.byte_idx = (tim_q.byte_idx == LAST_POS) ? '0 : tim_q.byte_idx + 1'b1;
                if (run) begin
                    tim_d.stb = 1'b1;
                    tim_d.pos = tim_q.byte_idx;
                    tim_d.fs  = (tim_q.byte_idx == '0);
                end
            end else begin
                tim_d.bit_idx = tim_q.bit_idx + 1'b1;
            end
        end
    end

    assign byte_stb    = tim_q.stb;
    assign frame_start = tim_q.fs;
    assign byte_pos    = tim_q.pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q <= '0;
        end else begin
            tim_q <= tim_d;
        end
    end
endmodule

// File: rtl/e3fa_ctrl.sv
module e3fa_ctrl
    import e3fa_pkg::*;
#(
    parameter int unsigned MISS_LIMIT = 4,
    parameter int unsigned MISS_W     = $clog2(MISS_LIMIT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_match,
    input  logic                  cand_busy,
    input  logic                  cand_done,
    input  logic                  cand_pass,
    input  logic                  check_pt,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic                  reg_addr,
    input  logic                  reg_wbit,
    output logic                  cand_start,
    output logic                  timer_load,
    output logic                  timer_run,
    output logic                  in_frame,
    output logic                  oof,
    output logic                  chg_stat,
    output logic                  irq_en,
    output logic                  irq,
    output logic [REG_DATA_W-1:0] reg_rdata
);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT - 1);

    typedef struct packed {
        fa_state_e         st;
        logic [MISS_W-1:0] miss;
        logic              stat;
        logic              en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic hunt_on;

    always_comb begin
        ctl_d      = ctl_q;
        timer_load = 1'b0;
        hunt_on    = (ctl_q.st == ST_HUNT) || ((ctl_q.st == ST_LOST) && !cand_busy);
        cand_start = hunt_on && word_match;
        unique case (ctl_q.st)
            ST_HUNT: begin
                if (cand_start) ctl_d.st = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (cand_done) begin
                    if (cand_pass) begin
                        ctl_d.st   = ST_LOCKED;
                        ctl_d.miss = '0;
                        timer_load = 1'b1;
                    end else begin
                        ctl_d.st = ST_HUNT;
                    end
                end
            end
            ST_LOCKED: begin
                if (check_pt) begin
                    if (word_match) begin
                        ctl_d.miss = '0;
                    end else if (ctl_q.miss == MISS_TOP) begin
                        ctl_d.st   = ST_LOST;
                        ctl_d.miss = '0;
                    end else begin
                        ctl_d.miss = ctl_q.miss + 1'b1;
                    end
                end
            end
            ST_LOST: begin
                if (cand_pass) begin
                    ctl_d.st   = ST_LOCKED;
                    timer_load = 1'b1;
                end
            end
            default: ctl_d.st = ST_HUNT;
        endcase
        if (reg_rd && !reg_addr) ctl_d.stat = 1'b0;
        if ((ctl_q.st == ST_LOST) != (ctl_d.st == ST_LOST)) ctl_d.stat = 1'b1;
        if (reg_wr && reg_addr) ctl_d.en = reg_wbit;
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[0]       = in_frame;
            reg_rdata[1]       = oof;
            reg_rdata[CHG_BIT] = ctl_q.stat;
        end else begin
            reg_rdata[EN_BIT]  = ctl_q.en;
        end
    end

    assign in_frame  = (ctl_q.st == ST_LOCKED);
    assign oof       = (ctl_q.st == ST_LOST);
    assign timer_run = in_frame || oof;
    assign chg_stat  = ctl_q.stat;
    assign irq_en    = ctl_q.en;
    assign irq       = ctl_q.stat && ctl_q.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_HUNT, miss: '0, stat: 1'b0, en: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/e3_frame_align.sv
module e3_frame_align
    import e3fa_pkg::*;
#(
    parameter int unsigned FRAME_BYTES = 537,
    parameter int unsigned WORD_W      = 16,
    parameter logic [WORD_W-1:0] WORD_VAL = 16'hF628,
    parameter int unsigned MISS_LIMIT  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_valid,
    input  logic                           bit_in,
    output logic                           byte_stb,
    output logic                           frame_start,
    output logic [$clog2(FRAME_BYTES)-1:0] byte_pos,
    output logic                           in_frame,
    output logic                           oof,
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic                           reg_addr,
    input  logic                           reg_wbit,
    output logic [REG_DATA_W-1:0]          reg_rdata,
    output logic                           irq
);
    localparam int unsigned FRAME_BITS = FRAME_BYTES * 8;
    localparam int unsigned POS_W      = $clog2(FRAME_BYTES);
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
    localparam int unsigned MISS_W     = $clog2(MISS_LIMIT + 1);

    logic word_match, cand_start, cand_busy, cand_done, cand_pass;
    logic check_pt, timer_load, timer_run, chg_stat, irq_en;

    e3fa_window #(.WORD_W(WORD_W), .WORD_VAL(WORD_VAL)) i_window (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .word_match(word_match)
    );

    e3fa_cand #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) i_cand (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .start(cand_start),
        .word_match(word_match), .busy(cand_busy), .done(cand_done), .pass(cand_pass)
    );

    e3fa_timer #(.FRAME_BYTES(FRAME_BYTES), .POS_W(POS_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .load(timer_load),
        .run(timer_run), .check_pt(check_pt), .byte_stb(byte_stb),
        .frame_start(frame_start), .byte_pos(byte_pos)
    );

    e3fa_ctrl #(.MISS_LIMIT(MISS_LIMIT), .MISS_W(MISS_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .word_match(word_match), .cand_busy(cand_busy),
        .cand_done(cand_done), .cand_pass(cand_pass), .check_pt(check_pt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wbit(reg_wbit),
        .cand_start(cand_start), .timer_load(timer_load), .timer_run(timer_run),
        .in_frame(in_frame), .oof(oof), .chg_stat(chg_stat), .irq_en(irq_en),
        .irq(irq), .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/e3fa_checker.sv
module e3fa_checker #(
    parameter int unsigned FRAME_BYTES = 537
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bit_valid,
    input logic                           byte_stb,
    input logic                           frame_start,
    input logic [$clog2(FRAME_BYTES)-1:0] byte_pos,
    input logic                           in_frame,
    input logic                           oof,
    input logic                           chg_stat
);
    // R5: a reported position never leaves the frame
    a_r5_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (int'(byte_pos) < FRAME_BYTES));

    // R5: frame start only with the strobe of position 0
    a_r5_fs_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (byte_stb && (byte_pos == '0)));

    // R5: no byte timing while hunting or verifying
    a_r5_stb_only_timed: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (in_frame || oof));

    // R10: a strobe always follows a consumed bit
    a_r10_stb_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(bit_valid));

    // R6: out-of-frame is entered only from lock
    a_r6_oof_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof) |-> $past(in_frame));

    // R8: every change of the out-of-frame flag leaves the status set
    a_r8_change_sets_stat: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oof) || $fell(oof)) |-> chg_stat);

    // R1: locked and lost are exclusive
    a_r1_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_frame && oof));
endmodule

bind e3_frame_align e3fa_checker #(.FRAME_BYTES(FRAME_BYTES)) i_e3fa_checker (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .byte_stb(byte_stb),
    .frame_start(frame_start), .byte_pos(byte_pos), .in_frame(in_frame),
    .oof(oof), .chg_stat(chg_stat)
);

// File: tb/test_e3_frame_align.sv
module test_e3_frame_align;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0, bit_in = 1'b0;
    logic       byte_stb, frame_start, in_frame, oof, irq;
    logic [9:0] byte_pos;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0, reg_wbit = 1'b0;
    logic [7:0] reg_rdata;

    int n_chk = 0, n_fail = 0, stb_err = 0, gap = 0;
    bit done_flag = 0;
    logic s_stb, s_fs, s_inf, s_oof;
    logic [9:0] s_pos;

    always #10 clk = ~clk;

    e3_frame_align i_e3_frame_align (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .byte_stb(byte_stb), .frame_start(frame_start), .byte_pos(byte_pos),
        .in_frame(in_frame), .oof(oof), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wbit(reg_wbit), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(posedge clk);
        @(negedge clk);
        s_stb = byte_stb; s_fs = frame_start; s_pos = byte_pos;
        s_inf = in_frame; s_oof = oof;
        bit_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // exp: -1 no strobe allowed, -2 not checked, >=0 expected position
    task automatic send_byte(input logic [7:0] v, input int exp);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        if (exp == -1 && s_stb) stb_err++;
        else if (exp >= 0 && (!s_stb || int'(s_pos) != exp || s_fs != (exp == 0))) stb_err++;
    endtask

    // mode 0: no strobes, 1: strobe positions checked, 2: unchecked
    task automatic send_range(input bit good, input int mimic, input int first,
                              input int last, input int mode);
        for (int b = first; b <= last; b++) begin
            logic [7:0] v;
            v = 8'h00;
            if (b == 0 && good) v = 8'hF6;
            if (b == 1 && good) v = 8'h28;
            if (b == mimic) v = 8'hF6;
            if (b == mimic + 1 && mimic >= 0) v = 8'h28;
            send_byte(v, mode == 1 ? b : (mode == 0 ? -1 : -2));
        end
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(input logic a, input logic v);
        reg_addr = a; reg_wbit = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        check("R1 in_frame", in_frame, 0);
        check("R1 oof", oof, 0);
        check("R1 byte_stb", byte_stb, 0);
        check("R1 frame_start", frame_start, 0);
        check("R1 irq", irq, 0);
        reg_read(1'b0, d); check("R1 status reg", d, 0);
        reg_read(1'b1, d); check("R1 enable reg", d, 0);
    endtask

    task automatic t_lock_lose_relock();
        logic [7:0] d;
        do_reset();
        reg_write(1'b1, 1'b1);
        reg_read(1'b1, d); check("R9 enable readback", d, 8'h08);
        stb_err = 0;
        send_range(1, -1, 0, 536, 0);
        send_range(1, -1, 0, 0, 0);
        check("R3 not locked before verify bit", s_inf, 0);
        send_range(1, -1, 1, 1, 0);
        check("R3 locked at verify bit", s_inf, 1);
        check("R5 no strobe before lock", stb_err, 0);
        stb_err = 0;
        send_range(1, -1, 2, 536, 1);
        reg_read(1'b0, d); check("R8 lock alone sets no change", d, 8'h01);
        for (int f = 0; f < 3; f++) send_range(0, -1, 0, 536, 1);
        send_range(1, -1, 0, 536, 1);
        for (int f = 0; f < 3; f++) send_range(0, -1, 0, 536, 1);
        check("R6 good frame clears miss count", s_inf, 1);
        check("R6 no oof after 3 misses", s_oof, 0);
        check("R5 positions while locked", stb_err, 0);
        send_range(0, -1, 0, 0, 1);
        check("R6 still locked before 4th check", s_inf, 1);
        send_range(0, -1, 1, 1, 1);
        check("R6 oof after 4th miss", s_oof, 1);
        check("R6 in_frame dropped", s_inf, 0);
        check("R9 irq on oof entry", irq, 1);
        reg_read(1'b0, d); check("R8 status on entry", d, 8'h0A);
        check("R8 irq cleared by read", irq, 0);
        reg_read(1'b0, d); check("R8 status cleared", d, 8'h02);
        stb_err = 0;
        send_range(0, -1, 2, 536, 1);
        check("R7 old timing continues in oof", stb_err, 0);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_range(1, -1, 0, 536, 2);
        check("R7 still oof during verify", s_oof, 1);
        send_range(1, -1, 0, 0, 2);
        check("R7 oof until verify bit", s_oof, 1);
        send_range(1, -1, 1, 1, 2);
        check("R7 relocked", s_inf, 1);
        check("R7 oof cleared", s_oof, 0);
        stb_err = 0;
        send_range(1, -1, 2, 536, 1);
        send_range(1, -1, 0, 536, 1);
        check("R7 new timing in force", stb_err, 0);
        check("R9 irq on oof exit", irq, 1);
        reg_write(1'b1, 1'b0);
        check("R9 irq masked", irq, 0);
        reg_read(1'b0, d); check("R8 status on exit", d, 8'h09);
        reg_read(1'b0, d); check("R8 status cleared after exit", d, 8'h01);
        reg_read(1'b1, d); check("R9 enable cleared", d, 0);
    endtask

    task automatic t_decoy();
        do_reset();
        stb_err = 0;
        send_range(1, 100, 50, 536, 0);
        send_range(1, -1, 0, 536, 0);
        check("R3 decoy rejected", s_inf, 0);
        send_range(1, -1, 0, 1, 0);
        check("R3 no hunt during verify", s_inf, 0);
        send_range(1, -1, 2, 536, 0);
        send_range(1, -1, 0, 1, 0);
        check("R4 lock after failed verify", s_inf, 1);
        check("R5 no strobe while unlocked", stb_err, 0);
    endtask

    task automatic t_gaps();
        do_reset();
        gap = 2;
        stb_err = 0;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        send_range(1, -1, 0, 536, 0);
        send_range(1, -1, 0, 0, 0);
        check("R2 R10 not locked early", s_inf, 0);
        send_range(1, -1, 1, 1, 0);
        check("R2 R10 lock with gaps and bit offset", s_inf, 1);
        send_range(1, -1, 2, 40, 1);
        check("R10 timing with gaps", stb_err, 0);
        gap = 0;
    endtask

    initial begin
        t_reset();
        t_lock_lose_relock();
        t_decoy();
        t_gaps();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule